// File: doc/BRIEF.md
# Write-Only I2C Receiver for a Display Controller

This block is the host-facing receive port of a small graphic display controller. It watches the I2C clock and data lines after synchronising them into the system clock. It detects start and stop conditions and compares the first byte of each transfer against a 7-bit slave address. The upper six bits of that address are fixed, and a strap input supplies the lowest bit. On a match with the write direction, the block pulls SDA low through an open-drain enable during the acknowledge clock. The byte after the address is a control byte. It is acknowledged but not forwarded, and it chooses whether the bytes that follow are commands or display data.

The block presents each received payload byte on a one-entry valid/ready output. A byte is handed over on a clock edge where `rx_valid` and `rx_ready` are both high. While `rx_valid` is high, the byte and its kind stay fixed. The block has no clock stretching. If a payload byte finishes while the output still holds an earlier byte, that new byte is not acknowledged. The rest of that transfer is then ignored until the next start condition. Read transfers and other addresses are never acknowledged, so the block stays silent on the bus for them.

Top module: `i2c_disp_rx`

## Requirements
- R1: The address byte is accepted and acknowledged only when its upper seven bits equal {6'b011110, addr_strap} and its last bit (direction) is 0. This gives 0x78 on the wire for strap 0 and 0x7A for strap 1. An acknowledge means SDA is held low for the whole high phase of the ninth clock.
- R2: An address byte that does not match is not acknowledged. Every later byte up to the next start is neither acknowledged nor forwarded.
- R3: A matching address with the direction bit set to 1 (read) is not acknowledged, and nothing is forwarded.
- R4: A repeated start in the middle of a transfer resets the bit and byte position. The next byte is then matched again as an address.
- R5: In the control byte, bit 6 sets the kind of the following payload bytes (1 = display data, 0 = command). With bit 7 at 0, every later byte in the transfer is payload of that kind.
- R6: With control bit 7 at 1, exactly one payload byte follows. The byte after it is treated as a new control byte.
- R7: Each control byte, and each payload byte that is accepted, is acknowledged. The payload bits are assembled MSB first and presented on `rx_byte` with `rx_is_data` giving the kind.
- R8: While `rx_valid` is high and `rx_ready` is low, `rx_valid`, `rx_byte` and `rx_is_data` hold. A payload byte that finishes while the slot is full is not acknowledged, and the transfer is ignored until the next start.
- R9: `sda_oe` changes only while the synchronised SCL is low, except when a start or stop clears it. It is released after the ninth clock falls and after any stop.
- R10: After reset, `sda_oe` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | I2C clock line level (asynchronous) |
| sda_in | input | 1 | I2C data line level (asynchronous) |
| addr_strap | input | 1 | Lowest slave address bit |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| rx_valid | output | 1 | A received payload byte is waiting |
| rx_ready | input | 1 | Consumer takes the byte on this edge when valid |
| rx_byte | output | 8 | Received payload byte |
| rx_is_data | output | 1 | 1 = display data, 0 = command |

## Verification
On every cycle, the assertions check that the SDA drive changes only while SCL is low, and that a stop releases it. They also check that a held output byte stays stable under back-pressure, that a byte enters the slot only when it is empty, and that nothing is driven or forwarded while a transfer is being ignored. Address matching for both strap values, and the silence on foreign addresses and reads, can only be shown by the bench's bus scenarios. The same holds for the two control-byte modes, for re-matching after a repeated start, and for the refused byte when the slot is full. In those scenarios, a scoreboard compares each forwarded byte and its kind against the order of the transfers.

// File: rtl/i2cd_pkg.sv
package i2cd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RECV,
    PH_DECIDE,
    PH_ACK,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_CTRL,
    BK_PAYLOAD
  } kind_t;
endpackage

// File: rtl/i2cd_bus_watch.sv
module i2cd_bus_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_seen,
  output logic stop_seen
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_in;
          sda_sh <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
          sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_lvl;
      sda_p <= sda_lvl;
    end
  end

  assign scl_lvl    = scl_sh[SYNC_STAGES-1];
  assign sda_lvl    = sda_sh[SYNC_STAGES-1];
  assign scl_rise   = scl_lvl & ~scl_p;
  assign scl_fall   = ~scl_lvl & scl_p;
  assign start_seen = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_seen  = scl_lvl & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/i2cd_rx_ctrl.sv
module i2cd_rx_ctrl
  import i2cd_pkg::*;
#(
  parameter int         BYTE_W  = 8,
  parameter logic [5:0] ADDR_HI = 6'b011110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_seen,
  input  logic              stop_seen,
  input  logic              addr_strap,
  input  logic              slot_free,
  output logic              sda_drive,
  output logic              push,
  output logic [BYTE_W-1:0] push_byte,
  output logic              push_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  phase_t             phase;
  kind_t              kind;
  logic [BYTE_W-1:0]  shreg;
  logic [CNT_W-1:0]   bitcnt;
  logic               stream_q, dc_q, oe_q, push_q;
  logic               addr_hit;

  assign addr_hit = (shreg[BYTE_W-1:1] == {ADDR_HI, addr_strap}) && !shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      kind     <= BK_ADDR;
      shreg    <= '0;
      bitcnt   <= '0;
      stream_q <= 1'b0;
      dc_q     <= 1'b0;
      oe_q     <= 1'b0;
      push_q   <= 1'b0;
    end else begin
      push_q <= 1'b0;
      if (start_seen) begin
        phase  <= PH_RECV;
        kind   <= BK_ADDR;
        bitcnt <= '0;
        oe_q   <= 1'b0;
      end else if (stop_seen) begin
        phase <= PH_IDLE;
        oe_q  <= 1'b0;
      end else begin
        unique case (phase)
          PH_RECV: if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == CNT_W'(BYTE_W - 1)) phase <= PH_DECIDE;
          end
          PH_DECIDE: if (scl_fall) begin
            unique case (kind)
              BK_ADDR: begin
                if (addr_hit) begin
                  phase <= PH_ACK;
                  oe_q  <= 1'b1;
                  kind  <= BK_CTRL;
                end else begin
                  phase <= PH_SKIP;
                end
              end
              BK_CTRL: begin
                phase    <= PH_ACK;
                oe_q     <= 1'b1;
                dc_q     <= shreg[6];
                stream_q <= ~shreg[7];
                kind     <= BK_PAYLOAD;
              end
              default: begin
                if (slot_free) begin
                  phase  <= PH_ACK;
                  oe_q   <= 1'b1;
                  push_q <= 1'b1;
                  if (!stream_q) kind <= BK_CTRL;
                end else begin
                  phase <= PH_SKIP;
                end
              end
            endcase
          end
          PH_ACK: if (scl_fall) begin
            oe_q   <= 1'b0;
            phase  <= PH_RECV;
            bitcnt <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_drive = oe_q;
  assign push      = push_q;
  assign push_byte = shreg;
  assign push_data = dc_q;

  a_r9_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(oe_q) && !$past(start_seen) && !$past(stop_seen)) |-> !$past(scl_lvl));
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_seen) |-> !oe_q);
  a_r8_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> $past(slot_free));
  a_r2_skip_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> (!oe_q && !push_q));
  a_r7_bitcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/i2cd_out_slot.sv
module i2cd_out_slot #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_byte,
  input  logic              push_data,
  output logic              slot_free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_data
);
  logic              v_q, d_q;
  logic [BYTE_W-1:0] b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= 1'b0;
      b_q <= '0;
    end else if (push) begin
      v_q <= 1'b1;
      d_q <= push_data;
      b_q <= push_byte;
    end else if (v_q && out_ready) begin
      v_q <= 1'b0;
    end
  end

  assign slot_free = ~v_q;
  assign out_valid = v_q;
  assign out_byte  = b_q;
  assign out_data  = d_q;

  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !out_ready) |=> (v_q && $stable(b_q) && $stable(d_q)));
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !v_q);
endmodule

// File: rtl/i2c_disp_rx.sv
module i2c_disp_rx #(
  parameter int         SYNC_STAGES = 2,
  parameter int         BYTE_W      = 8,
  parameter logic [5:0] ADDR_HI     = 6'b011110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              addr_strap,
  output logic              sda_oe,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_is_data
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_seen, stop_seen;
  logic slot_free, push, push_data;
  logic [BYTE_W-1:0] push_byte;

  i2cd_bus_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_seen(start_seen), .stop_seen(stop_seen)
  );

  i2cd_rx_ctrl #(.BYTE_W(BYTE_W), .ADDR_HI(ADDR_HI)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_seen(start_seen),
    .stop_seen(stop_seen), .addr_strap(addr_strap), .slot_free(slot_free),
    .sda_drive(sda_oe), .push(push), .push_byte(push_byte), .push_data(push_data)
  );

  i2cd_out_slot #(.BYTE_W(BYTE_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .push(push), .push_byte(push_byte),
    .push_data(push_data), .slot_free(slot_free), .out_valid(rx_valid),
    .out_ready(rx_ready), .out_byte(rx_byte), .out_data(rx_is_data)
  );
endmodule

// File: tb/i2c_disp_rx_test.sv
module i2c_disp_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_strap = 1'b0;
  logic rx_ready = 1'b1;
  logic sda_oe, rx_valid, rx_is_data;
  logic [7:0] rx_byte;
  logic sda_line;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [8:0] expq[$];

  assign sda_line = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_disp_rx uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .addr_strap(addr_strap), .sda_oe(sda_oe), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_byte(rx_byte), .rx_is_data(rx_is_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = !sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_expect(input logic [7:0] b, input bit exp_ack, input string tag);
    bit a;
    send_byte(b, a);
    check(a == exp_ack, tag, a, exp_ack);
  endtask

  task automatic payload(input logic [7:0] b, input bit is_data, input string tag);
    expq.push_back({is_data, b});
    send_expect(b, 1'b1, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2/R7 unexpected byte", {rx_is_data, rx_byte}, 0);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        check({rx_is_data, rx_byte} == e, "R7 byte/kind", {rx_is_data, rx_byte}, e);
      end
    end
  end

  task automatic drain(input string tag);
    tick(10);
    check(expq.size() == 0, tag, expq.size(), 0);
  endtask

  initial begin
    tick(5);
    check(sda_oe == 1'b0, "R10 sda_oe", sda_oe, 0);
    check(rx_valid == 1'b0, "R10 rx_valid", rx_valid, 0);
    rst_n = 1'b1;
    tick(5);

    // R1/R5 strap 0, command stream
    addr_strap = 1'b0;
    bus_start();
    send_expect(8'h78, 1'b1, "R1 addr strap0");
    send_expect(8'h00, 1'b1, "R5 ctrl ack");
    payload(8'hAE, 1'b0, "R5 cmd stream");
    payload(8'hA5, 1'b0, "R5 cmd stream");
    bus_stop();
    drain("R5 drained");
    check(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);

    // R1/R5 strap 1, data stream, and the other address refused
    addr_strap = 1'b1;
    bus_start();
    send_expect(8'h7A, 1'b1, "R1 addr strap1");
    send_expect(8'h40, 1'b1, "R5 ctrl ack");
    payload(8'h12, 1'b1, "R5 data stream");
    payload(8'h34, 1'b1, "R5 data stream");
    bus_stop();
    bus_start();
    send_expect(8'h78, 1'b0, "R1 wrong strap nack");
    send_expect(8'h40, 1'b0, "R2 ignored after nack");
    bus_stop();
    drain("R5 strap1 drained");

    // R2 foreign address
    addr_strap = 1'b0;
    bus_start();
    send_expect(8'hA0, 1'b0, "R2 foreign nack");
    send_expect(8'h40, 1'b0, "R2 ctrl ignored");
    send_expect(8'h99, 1'b0, "R2 payload ignored");
    check(rx_valid == 1'b0, "R2 nothing forwarded", rx_valid, 0);
    bus_stop();

    // R3 read to own address
    bus_start();
    send_expect(8'h79, 1'b0, "R3 read nack");
    send_expect(8'h00, 1'b0, "R3 ignored");
    check(rx_valid == 1'b0, "R3 nothing forwarded", rx_valid, 0);
    bus_stop();

    // R6 single-byte control mode
    bus_start();
    send_expect(8'h78, 1'b1, "R6 addr");
    send_expect(8'h80, 1'b1, "R6 ctrl cmd single");
    payload(8'hAE, 1'b0, "R6 single cmd");
    send_expect(8'hC0, 1'b1, "R6 ctrl data single");
    payload(8'h55, 1'b1, "R6 single data");
    send_expect(8'h00, 1'b1, "R6 ctrl cmd stream");
    payload(8'h11, 1'b0, "R6 stream cmd");
    payload(8'h22, 1'b0, "R6 stream cmd");
    bus_stop();
    drain("R6 drained");

    // R4 repeated start
    bus_start();
    send_expect(8'h78, 1'b1, "R4 addr");
    send_expect(8'h40, 1'b1, "R4 ctrl");
    payload(8'h01, 1'b1, "R4 before restart");
    bus_start();
    send_expect(8'h78, 1'b1, "R4 re-match addr");
    send_expect(8'h00, 1'b1, "R4 new ctrl");
    payload(8'h02, 1'b0, "R4 after restart");
    bus_start();
    send_expect(8'h79, 1'b0, "R4 restart read nack");
    bus_stop();
    drain("R4 drained");

    // R8 back-pressure
    rx_ready = 1'b0;
    bus_start();
    send_expect(8'h78, 1'b1, "R8 addr");
    send_expect(8'h40, 1'b1, "R8 ctrl");
    expq.push_back({1'b1, 8'h5A});
    send_expect(8'h5A, 1'b1, "R8 first accepted");
    send_expect(8'hC3, 1'b0, "R8 full slot nack");
    send_expect(8'h77, 1'b0, "R8 rest ignored");
    check(rx_valid == 1'b1, "R8 valid held", rx_valid, 1);
    check(rx_byte == 8'h5A, "R8 byte held", rx_byte, 8'h5A);
    check(rx_is_data == 1'b1, "R8 kind held", rx_is_data, 1);
    bus_stop();
    rx_ready = 1'b1;
    drain("R8 drained");
    check(rx_valid == 1'b0, "R8 slot emptied", rx_valid, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule